// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block sits beside a small processor core and decides, at each instruction boundary, whether an interrupt is taken and where the service routine starts. It watches five request sources: one non-maskable trap, three maskable restart lines and one general request. It applies a global enable, which the core sets and clears with strobes, and a per-line mask register for the restart lines. When a request wins, the block presents a 16-bit start address for one cycle with a valid flag.

The trap and the restart lines have fixed start addresses. The general request works differently. The block drives an active-low acknowledge pulse, and the external hardware places an instruction byte on the data bus during that pulse. The block captures the byte. If the byte is a restart opcode, the block turns it into that restart's start address. Taking any maskable request clears the global enable, so the handler must re-enable interrupts itself. Pushing the return address is left to the core.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset `vec_valid_o` is 0, `vec_addr_o` and `op_o` are 0, `inta_n_o` is 1, the global enable is clear and all three mask bits are set (masked).
- R2: The trap line is recognised on a rising edge of `trap_i`. It is taken at a later boundary strobe only while `trap_i` is still high, regardless of the enable and the masks, and gives address 0x0024. The trap is taken once per rising edge. A trap that falls before a boundary strobe is dropped.
- R3: Restart line `rst_req_i[i]` (i = 0, 1, 2) gives address 0x002C, 0x0034 or 0x003C. It is taken only when the global enable is set and mask bit i is 0. A mask bit of 1 blocks its line.
- R4: When several requests are eligible at once, the priority is trap, then line 2, then line 1, then line 0, then the general request.
- R5: Requests are evaluated only in a cycle with `boundary_i` high. A fixed-vector result shows `vec_valid_o` in the cycle after that strobe.
- R6: Accepting a restart or general request clears the global enable. Accepting the trap leaves the enable unchanged.
- R7: `en_set_i` sets the global enable and `en_clr_i` clears it. When both are high in the same cycle, the enable ends up clear.
- R8: The general request `gen_req_i` is taken only with the enable set. `inta_n_o` then goes low in the cycle after the strobe and stays low for ACK_LEN cycles. `data_i` is captured in the last low cycle. In the next cycle `vec_valid_o` is high and `op_o` holds the captured byte.
- R9: A captured byte of the form 11nnn111 gives address n*8; for example, 0xE7 gives 0x0020. Any other byte gives address 0x0000. Every valid address is below 0x0040.
- R10: Boundary strobes that arrive while the acknowledge pulse is in progress are ignored. A trap that rises during the pulse is taken at the first strobe after the pulse ends.
- R11: `vec_valid_o` lasts one cycle per accepted request. When it is low, `vec_addr_o` and `op_o` are 0. For trap and restart results, `op_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_i | input | 1 | Non-maskable trap request |
| rst_req_i | input | 3 | Maskable restart requests, level sensitive |
| gen_req_i | input | 1 | General interrupt request |
| en_set_i | input | 1 | Strobe that sets the global enable |
| en_clr_i | input | 1 | Strobe that clears the global enable |
| mask_we_i | input | 1 | Mask register write strobe |
| mask_wdata_i | input | 3 | New mask bits, 1 = masked |
| boundary_i | input | 1 | Instruction-boundary strobe from the core |
| data_i | input | 8 | Data bus carrying the external instruction byte |
| vec_valid_o | output | 1 | Start address valid, one cycle |
| vec_addr_o | output | 16 | Service routine start address |
| op_o | output | 8 | Captured instruction byte (general request only) |
| inta_n_o | output | 1 | Active-low acknowledge pulse |

## Verification
The restart lines are driven all high together, in pairs and singly, under different masks. These patterns separate priority ordering from mask gating. Trap stimulus covers:
- a rising edge that is held high, which must be taken exactly once;
- a pulse that falls before the strobe, which must be dropped;
- a rise during an acknowledge pulse, which must be deferred.

The general path is driven with junk data on the bus early in the pulse and the real byte only in the last cycle, which shows when the byte is captured. Restart-form and non-restart bytes separate the two decode cases. The enable is toggled with single, simultaneous and absent strobes to show where acceptance clears it.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam logic [ADDR_W-1:0] TRAP_VEC = 16'h0024;
    localparam logic [ADDR_W-1:0] LINE_BASE = 16'h002C;
    localparam logic [ADDR_W-1:0] LINE_STEP = 16'h0008;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_ACK  = 1'b1
    } ctl_st_e;

    // Restart opcode 11nnn111 -> n*8, any other byte -> 0
    function automatic logic [ADDR_W-1:0] op_to_addr(input logic [DATA_W-1:0] op);
        logic [ADDR_W-1:0] a;
        a = '0;
        if (op[7:6] == 2'b11 && op[2:0] == 3'b111)
            a[5:3] = op[5:3];
        return a;
    endfunction
endpackage

// File: rtl/irqv_trap_latch.sv
module irqv_trap_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic trap_i,
    input  logic clr_i,
    output logic pend_o
);
    logic prev_d, prev_q;
    logic pend_d, pend_q;

    always_comb begin
        prev_d = trap_i;
        pend_d = (pend_q & trap_i) | (trap_i & ~prev_q);
        if (clr_i)
            pend_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            prev_q <= prev_d;
            pend_q <= pend_d;
        end
    end

    assign pend_o = pend_q & trap_i;
endmodule

// File: rtl/irqv_prio.sv
module irqv_prio #(
    parameter int NUM_LINES = 3
) (
    input  logic                          trap_ok_i,
    input  logic [NUM_LINES-1:0]          line_ok_i,
    input  logic                          gen_ok_i,
    output logic                          sel_trap_o,
    output logic                          sel_line_o,
    output logic                          sel_gen_o,
    output logic [irqv_pkg::ADDR_W-1:0]   line_addr_o
);
    import irqv_pkg::*;

    always_comb begin
        logic found;
        found       = trap_ok_i;
        sel_trap_o  = trap_ok_i;
        sel_line_o  = 1'b0;
        line_addr_o = '0;
        for (int i = NUM_LINES - 1; i >= 0; i--) begin
            if (!found && line_ok_i[i]) begin
                found       = 1'b1;
                sel_line_o  = 1'b1;
                line_addr_o = LINE_BASE + ADDR_W'(i) * LINE_STEP;
            end
        end
        sel_gen_o = !found && gen_ok_i;
    end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
    parameter int NUM_LINES = 3,
    parameter int ACK_LEN   = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         trap_i,
    input  logic [NUM_LINES-1:0]         rst_req_i,
    input  logic                         gen_req_i,
    input  logic                         en_set_i,
    input  logic                         en_clr_i,
    input  logic                         mask_we_i,
    input  logic [NUM_LINES-1:0]         mask_wdata_i,
    input  logic                         boundary_i,
    input  logic [irqv_pkg::DATA_W-1:0]  data_i,
    output logic                         vec_valid_o,
    output logic [irqv_pkg::ADDR_W-1:0]  vec_addr_o,
    output logic [irqv_pkg::DATA_W-1:0]  op_o,
    output logic                         inta_n_o
);
    import irqv_pkg::*;

    localparam int CW = (ACK_LEN < 2) ? 1 : $clog2(ACK_LEN);
    localparam logic [CW-1:0] CNT_LAST = CW'(ACK_LEN - 1);

    typedef struct packed {
        ctl_st_e              st;
        logic                 gie;
        logic [NUM_LINES-1:0] mask;
        logic [CW-1:0]        cnt;
        logic                 vld;
        logic [ADDR_W-1:0]    addr;
        logic [DATA_W-1:0]    op;
    } ctl_t;

    ctl_t r_d, r_q;

    logic                 trap_ok;
    logic [NUM_LINES-1:0] line_ok;
    logic                 gen_ok;
    logic                 eval;
    logic                 sel_trap, sel_line, sel_gen;
    logic [ADDR_W-1:0]    line_addr;
    logic                 trap_clr;

    assign eval     = boundary_i && (r_q.st == ST_IDLE);
    assign trap_clr = eval && sel_trap;
    assign line_ok  = rst_req_i & ~r_q.mask & {NUM_LINES{r_q.gie}};
    assign gen_ok   = gen_req_i & r_q.gie;

    irqv_trap_latch u_trap (
        .clk    (clk),
        .rst_n  (rst_n),
        .trap_i (trap_i),
        .clr_i  (trap_clr),
        .pend_o (trap_ok)
    );

    irqv_prio #(.NUM_LINES(NUM_LINES)) u_prio (
        .trap_ok_i   (trap_ok),
        .line_ok_i   (line_ok),
        .gen_ok_i    (gen_ok),
        .sel_trap_o  (sel_trap),
        .sel_line_o  (sel_line),
        .sel_gen_o   (sel_gen),
        .line_addr_o (line_addr)
    );

    always_comb begin
        r_d      = r_q;
        r_d.vld  = 1'b0;
        r_d.addr = '0;
        r_d.op   = '0;
        if (en_set_i)
            r_d.gie = 1'b1;
        if (en_clr_i)
            r_d.gie = 1'b0;
        if (mask_we_i)
            r_d.mask = mask_wdata_i;
        case (r_q.st)
            ST_IDLE: begin
                if (eval) begin
                    if (sel_trap) begin
                        r_d.vld  = 1'b1;
                        r_d.addr = TRAP_VEC;
                    end else if (sel_line) begin
                        r_d.vld  = 1'b1;
                        r_d.addr = line_addr;
                        r_d.gie  = 1'b0;
                    end else if (sel_gen) begin
                        r_d.st  = ST_ACK;
                        r_d.cnt = '0;
                        r_d.gie = 1'b0;
                    end
                end
            end
            ST_ACK: begin
                if (r_q.cnt == CNT_LAST) begin
                    r_d.st   = ST_IDLE;
                    r_d.vld  = 1'b1;
                    r_d.addr = op_to_addr(data_i);
                    r_d.op   = data_i;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st   <= ST_IDLE;
            r_q.gie  <= 1'b0;
            r_q.mask <= '1;
            r_q.cnt  <= '0;
            r_q.vld  <= 1'b0;
            r_q.addr <= '0;
            r_q.op   <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign vec_valid_o = r_q.vld;
    assign vec_addr_o  = r_q.addr;
    assign op_o        = r_q.op;
    assign inta_n_o    = (r_q.st != ST_ACK);
endmodule

// File: rtl/irqv_chk.sv
module irqv_chk (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        boundary_i,
    input logic                        inta_n_o,
    input logic                        vec_valid_o,
    input logic [irqv_pkg::ADDR_W-1:0] vec_addr_o,
    input logic [irqv_pkg::DATA_W-1:0] op_o
);
    // R5: a result follows a strobe or the end of an acknowledge pulse
    assert_valid_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid_o |-> ($past(boundary_i) || $rose(inta_n_o)));

    // R8: the acknowledge pulse starts only after a boundary strobe
    assert_ack_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(inta_n_o) |-> $past(boundary_i));

    // R8: the end of the pulse delivers a result
    assert_ack_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(inta_n_o) |-> vec_valid_o);

    // R8: no result while the pulse is low
    assert_no_vld_in_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !inta_n_o |-> !vec_valid_o);

    // R9: every start address lies below 0x0040
    assert_addr_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid_o |-> (vec_addr_o[irqv_pkg::ADDR_W-1:6] == '0));

    // R11: outputs are quiet without a valid result
    assert_quiet_outputs_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_valid_o |-> (vec_addr_o == '0 && op_o == '0));
endmodule

bind irq_vector_ctrl irqv_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .boundary_i  (boundary_i),
    .inta_n_o    (inta_n_o),
    .vec_valid_o (vec_valid_o),
    .vec_addr_o  (vec_addr_o),
    .op_o        (op_o)
);

// File: tb/sim_irq_vector_ctrl.sv
`timescale 1ns/1ps
module sim_irq_vector_ctrl;
    localparam int ACK_LEN = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       trap = 1'b0;
    logic [2:0] rreq = 3'b000;
    logic       gen = 1'b0;
    logic       en_set = 1'b0, en_clr = 1'b0;
    logic       mask_we = 1'b0;
    logic [2:0] mask_wd = 3'b000;
    logic       bnd = 1'b0;
    logic [7:0] data = 8'h00;
    logic       vld;
    logic [15:0] addr;
    logic [7:0] op;
    logic       inta_n;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [23:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    irq_vector_ctrl #(.NUM_LINES(3), .ACK_LEN(ACK_LEN)) u0 (
        .clk(clk), .rst_n(rst_n), .trap_i(trap), .rst_req_i(rreq),
        .gen_req_i(gen), .en_set_i(en_set), .en_clr_i(en_clr),
        .mask_we_i(mask_we), .mask_wdata_i(mask_wd), .boundary_i(bnd),
        .data_i(data), .vec_valid_o(vld), .vec_addr_o(addr), .op_o(op),
        .inta_n_o(inta_n)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: pops the scoreboard on every result
    always @(negedge clk) begin
        if (rst_n && vld && !done) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "unexpected result", {8'h0, op, addr}, 32'h0);
            end else begin
                logic [23:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk({op, addr} == e, t, {8'h0, op, addr}, {8'h0, e});
            end
        end
    end

    task automatic push(input logic [15:0] a, input logic [7:0] o, input string t);
        exp_q.push_back({o, a});
        tag_q.push_back(t);
    endtask

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic strobe;
        bnd = 1'b1;
        tick();
        bnd = 1'b0;
    endtask

    task automatic enable;
        en_set = 1'b1;
        tick();
        en_set = 1'b0;
    endtask

    task automatic write_mask(input logic [2:0] m);
        mask_we = 1'b1;
        mask_wd = m;
        tick();
        mask_we = 1'b0;
    endtask

    task automatic no_result(input string req);
        chk(vld == 1'b0, req, {31'h0, vld}, 32'h0);
    endtask

    // walks the acknowledge pulse; final byte only in the last low cycle
    task automatic ack_walk(input logic [7:0] junk, input logic [7:0] fin, input string req);
        for (int i = 0; i < ACK_LEN; i++) begin
            chk(inta_n == 1'b0, req, {31'h0, inta_n}, 32'h0);
            data = (i == ACK_LEN - 1) ? fin : junk;
            tick();
        end
        chk(inta_n == 1'b1, req, {31'h0, inta_n}, 32'h1);
        data = 8'h00;
    endtask

    initial begin
        for (int c = 0; c < 20000; c++) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            bad++;
            total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick();
        // R1: reset values
        chk(vld == 1'b0 && inta_n == 1'b1, "R1 reset outputs", {30'h0, vld, inta_n}, 32'h1);
        chk(addr == 16'h0 && op == 8'h0, "R1 reset address", {8'h0, op, addr}, 32'h0);

        // R1/R3: enable clear at reset blocks restart lines
        rreq = 3'b111;
        strobe();
        no_result("R1 enable clear after reset");
        // R1: masks all set at reset
        enable();
        strobe();
        no_result("R1 masks set after reset");

        // R3: line 0 alone, R6 enable cleared afterwards
        write_mask(3'b000);
        rreq = 3'b001;
        push(16'h002C, 8'h00, "R3 line0 vector");
        strobe();
        tick();
        strobe();
        no_result("R6 enable cleared by restart");

        // R4: all lines -> line 2; lines 1,0 -> line 1
        enable();
        rreq = 3'b111;
        push(16'h003C, 8'h00, "R4 line2 highest line");
        strobe();
        enable();
        rreq = 3'b011;
        push(16'h0034, 8'h00, "R4 line1 over line0");
        strobe();

        // R3: mask bit 2 blocks line 2
        write_mask(3'b100);
        enable();
        rreq = 3'b111;
        push(16'h0034, 8'h00, "R3 mask blocks line2");
        strobe();

        // R5: no evaluation without a strobe
        enable();
        rreq = 3'b001;
        tick(5);
        no_result("R5 no strobe no result");

        // R4/R2/R6: trap beats lines, leaves enable set
        rreq = 3'b111;
        trap = 1'b1;
        tick();
        push(16'h0024, 8'h00, "R4 trap highest");
        strobe();
        push(16'h0034, 8'h00, "R6 trap keeps enable");
        strobe();
        rreq = 3'b000;

        // R2: held-high trap not taken twice
        enable();
        strobe();
        no_result("R2 trap once per edge");

        // R2: trap that falls before the strobe is dropped
        trap = 1'b0;
        tick();
        trap = 1'b1;
        tick();
        trap = 1'b0;
        tick();
        strobe();
        no_result("R2 dropped trap");

        // R8/R9: general request with restart 4 byte
        gen = 1'b1;
        push(16'h0020, 8'hE7, "R9 byte E7 to 0x0020");
        strobe();
        ack_walk(8'h55, 8'hE7, "R8 ack pulse E7");
        tick();

        // R8: without enable the general request is ignored
        strobe();
        no_result("R8 general needs enable");
        chk(inta_n == 1'b1, "R8 no pulse without enable", {31'h0, inta_n}, 32'h1);

        // R4: line 0 beats general request
        enable();
        write_mask(3'b000);
        rreq = 3'b001;
        push(16'h002C, 8'h00, "R4 line0 over general");
        strobe();
        rreq = 3'b000;

        // R8: capture in last cycle, R9 restart 1 byte CF
        enable();
        push(16'h0008, 8'hCF, "R8 capture last cycle");
        strobe();
        ack_walk(8'h00, 8'hCF, "R8 ack pulse CF");

        // R9: non-restart byte -> 0x0000
        enable();
        push(16'h0000, 8'h3A, "R9 non-restart byte");
        strobe();
        ack_walk(8'hFF, 8'h3A, "R8 ack pulse 3A");

        // R10: strobes and a trap rise during the pulse
        trap = 1'b0;
        enable();
        push(16'h0000, 8'h8C, "R10 general result first");
        push(16'h0024, 8'h00, "R10 deferred trap");
        strobe();
        bnd = 1'b1;
        trap = 1'b1;
        ack_walk(8'h11, 8'h8C, "R10 pulse unbroken");
        tick();
        bnd = 1'b0;
        gen = 1'b0;
        tick(2);
        trap = 1'b0;

        // R7: set and clear together leave enable clear
        rreq = 3'b001;
        en_set = 1'b1;
        en_clr = 1'b1;
        tick();
        en_set = 1'b0;
        en_clr = 1'b0;
        strobe();
        no_result("R7 clear wins");
        enable();
        push(16'h002C, 8'h00, "R7 set alone");
        strobe();
        rreq = 3'b000;

        tick(4);
        // R11: outputs quiet and every expected result seen
        chk(vld == 1'b0 && addr == 16'h0 && op == 8'h0, "R11 quiet outputs", {8'h0, op, addr}, 32'h0);
        chk(exp_q.size() == 0, "R11 all results seen", exp_q.size(), 32'h0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule